// File: doc/BRIEF.md
# Reference-Window Frequency and Pulse-Width Meter

This block measures a target clock against a reference clock, and both clocks are sampled as ordinary inputs in one faster system clock domain. It has two modes. In frequency mode it counts target rising edges over a window of 2^N reference periods. The window opens on the first reference rising edge after the start command. In pulse-width mode it counts target rising edges across one phase of the reference input. A polarity bit picks the high phase or the low phase.

A single write-only 32-bit control word sets the window exponent, the mode and the polarity. The same word also starts or aborts a measurement. The busy flag is visible at all times. The captured count is visible only while the unit is idle. Each clock input passes through a two-flop synchronizer and an edge detector before it is used, so the system clock must run faster than either measured clock.

Top module: `freq_pulse_meter`

## Requirements
- R1: After reset, `busy` is 0 and `result` is 0. All configuration fields also reset to 0, which selects frequency mode with N = 0.
- R2: A write with bit 31 = 1 makes `busy` read 1 from the next clock onward, until the measurement ends or is aborted.
- R3: In frequency mode (bit 8 = 0), counting starts at the first synchronized reference rising edge after the write. The result is the number of target rising edges seen in the window, so it equals 2^N times the ratio of the reference period to the target period, within ±1.
- R4: Bits 4:0 of the written word give N, from 0 to 31. The window closes on the 2^N-th reference rising edge after the opening edge. With N = 0 the window is a single reference period.
- R5: In pulse-width mode (bit 8 = 1) with bit 9 = 0, the count opens on a reference rising edge and closes on the following falling edge. The result is the target edge count over the high phase.
- R6: In pulse-width mode with bit 9 = 1, the count opens on a reference falling edge and closes on the following rising edge. The result is the target edge count over the low phase.
- R7: `busy` returns to 0 on its own when the closing edge arrives. `result` reads 0 while `busy` is 1. While idle, `result` holds the final count unchanged.
- R8: A write with bit 31 = 1 during an active measurement abandons that measurement. A new one starts under the newly written configuration.
- R9: A write with bit 31 = 0 stops any active measurement: `busy` falls on the next clock and `result` is cleared to 0. If the unit is already idle, the same write only clears `result`.
- R10: The target count saturates at all ones (2^CNT_W − 1) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both measured clocks |
| rstN | input | 1 | Active-low synchronous reset |
| refClkIn | input | 1 | Reference clock, sampled asynchronously |
| tgtClkIn | input | 1 | Target clock, sampled asynchronously |
| ctrlWrEn | input | 1 | Strobe that writes the control word |
| ctrlWrData | input | 32 | Control word: [4:0] N, [8] mode, [9] polarity, [31] start/abort |
| busy | output | 1 | High while a measurement is armed or counting |
| result | output | CNT_W | Final target count; reads 0 while busy |

## Verification
Several corner cases are targeted directly.

- **N = 0 window.** An off-by-one in the window compare would return double the count or close at once.
- **Polarity bit.** A swapped polarity decode would turn the 30-cycle high-phase measurement into the 10-cycle low one.
- **Restart during a measurement.** It must give the count for the second configuration. A design that ignored the second start would report the longer first window.
- **Abort write.** It must drop `busy` on the very next clock and zero the result.
- **Long window against a narrowed counter.** This checks that the count pins at all ones. A counter that wraps would report a small residue.

A behavioural model compares `busy` and `result` on every clock, which also catches a start that does not wait for the reference edge.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Control word field positions (behavioural: software writes these bits)
  localparam int EXP_W    = 5;
  localparam int EXP_LSB  = 0;
  localparam int MODE_BIT = 8;
  localparam int POL_BIT  = 9;
  localparam int GO_BIT   = 31;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2
  } fsmState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCounts;
    logic countEn;
    logic capture;
    logic clrResult;
  } ctrlStrobes_t;

endpackage

// File: rtl/fpm_sync_edge.sv
module fpm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseOut,
  output logic fallOut
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[CHAIN_W-2:0], asyncIn};
  end

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  assign riseOut =  chain[STAGES-1] & ~chain[STAGES];
  assign fallOut = ~chain[STAGES-1] &  chain[STAGES];

endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrGo,
  input  logic             wrMode,
  input  logic             wrPol,
  input  logic [EXP_W-1:0] wrExp,
  input  logic             refRise,
  input  logic             refFall,
  input  logic             refAtLimit,
  output ctrlStrobes_t     strb,
  output logic [EXP_W-1:0] expSel,
  output logic             busy
);
  fsmState_t stateQ, stateD;
  logic      modePulseQ;
  logic      polLowQ;
  logic      trigEdge;
  logic      endEdge;
  logic      measDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expSel     <= '0;
      modePulseQ <= 1'b0;
      polLowQ    <= 1'b0;
    end else if (wrEn) begin
      expSel     <= wrExp;
      modePulseQ <= wrMode;
      polLowQ    <= wrPol;
    end
  end

  always_comb begin
    trigEdge = modePulseQ ? (polLowQ ? refFall : refRise) : refRise;
    endEdge  = polLowQ ? refRise : refFall;
    measDone = modePulseQ ? endEdge : (refRise && refAtLimit);
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    if (wrEn) begin
      if (wrGo) begin
        stateD         = ST_ARM;
        strb.clrCounts = 1'b1;
      end else begin
        stateD         = ST_IDLE;
        strb.clrResult = 1'b1;
      end
    end else begin
      unique case (stateQ)
        ST_ARM: begin
          if (trigEdge) begin
            stateD         = ST_COUNT;
            strb.clrCounts = 1'b1;
          end
        end
        ST_COUNT: begin
          strb.countEn = 1'b1;
          if (measDone) begin
            strb.capture = 1'b1;
            stateD       = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrGo) |=> busy);

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrGo) |=> !busy);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_COUNT && !wrEn && measDone) |=> !busy);

endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int REF_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic             tgtRise,
  input  logic             refRise,
  input  logic [EXP_W-1:0] expSel,
  input  logic             busy,
  output logic             refAtLimit,
  output logic [CNT_W-1:0] result
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [REF_W:0]   ONE_W   = (REF_W+1)'(1);

  logic [CNT_W-1:0] tgtCnt;
  logic [CNT_W-1:0] tgtNext;
  logic [REF_W-1:0] refCnt;
  logic [CNT_W-1:0] resultQ;

  always_comb begin
    if (tgtCnt == CNT_MAX) tgtNext = CNT_MAX;
    else                   tgtNext = tgtCnt + CNT_W'(tgtRise);
  end

  // Window closes when the count of rises since the opening edge reaches 2^N
  assign refAtLimit = (({1'b0, refCnt} + ONE_W) == (ONE_W << expSel));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtCnt <= '0;
      refCnt <= '0;
    end else if (strb.clrCounts) begin
      tgtCnt <= '0;
      refCnt <= '0;
    end else if (strb.countEn) begin
      tgtCnt <= tgtNext;
      if (refRise) refCnt <= refCnt + REF_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              resultQ <= '0;
    else if (strb.clrResult) resultQ <= '0;
    else if (strb.capture)   resultQ <= tgtNext;
  end

  assign result = busy ? '0 : resultQ;

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countEn && !strb.clrCounts && tgtCnt == CNT_MAX) |=> (tgtCnt == CNT_MAX));

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !strb.capture && !strb.clrResult) |=> $stable(resultQ));

  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrResult |=> (resultQ == '0));

endmodule

// File: rtl/freq_pulse_meter.sv
module freq_pulse_meter
  import fpm_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int REF_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refClkIn,
  input  logic             tgtClkIn,
  input  logic             ctrlWrEn,
  input  logic [31:0]      ctrlWrData,
  output logic             busy,
  output logic [CNT_W-1:0] result
);
  logic         refRise, refFall, tgtRise, tgtFallUnused;
  logic         refAtLimit;
  ctrlStrobes_t strb;
  logic [EXP_W-1:0] expSel;
  logic         reservedBitsUnused;

  assign reservedBitsUnused = ^{ctrlWrData[30:10], ctrlWrData[7:5]};

  fpm_sync_edge #(.STAGES(SYNC_STAGES)) refSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(refClkIn),
    .riseOut(refRise), .fallOut(refFall));

  fpm_sync_edge #(.STAGES(SYNC_STAGES)) tgtSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(tgtClkIn),
    .riseOut(tgtRise), .fallOut(tgtFallUnused));

  fpm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .wrEn(ctrlWrEn),
    .wrGo(ctrlWrData[GO_BIT]),
    .wrMode(ctrlWrData[MODE_BIT]),
    .wrPol(ctrlWrData[POL_BIT]),
    .wrExp(ctrlWrData[EXP_LSB +: EXP_W]),
    .refRise(refRise), .refFall(refFall),
    .refAtLimit(refAtLimit),
    .strb(strb), .expSel(expSel), .busy(busy));

  fpm_datapath #(.CNT_W(CNT_W), .REF_W(REF_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .tgtRise(tgtRise), .refRise(refRise),
    .expSel(expSel), .busy(busy),
    .refAtLimit(refAtLimit), .result(result));

endmodule

// File: tb/freq_pulse_meter_tb_top.sv
`timescale 1ns/1ps
module freq_pulse_meter_tb_top;
  localparam int TB_CNT_W = 12;
  localparam longint CNT_MAX = (64'd1 << TB_CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0;
  logic tgtIn = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic busy;
  logic [TB_CNT_W-1:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  freq_pulse_meter #(.CNT_W(TB_CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .refClkIn(refIn), .tgtClkIn(tgtIn),
    .ctrlWrEn(wrEn), .ctrlWrData(wrData), .busy(busy), .result(result));

  // Stimulus clocks, advanced on the falling system edge
  int refHi = 10, refLo = 10, tgtHalf = 2;
  int refPh = 0, tgtPh = 0;
  always @(negedge clk) begin
    if (refPh >= (refIn ? refHi : refLo) - 1) begin refIn <= ~refIn; refPh = 0; end
    else refPh++;
    if (tgtPh >= tgtHalf - 1) begin tgtIn <= ~tgtIn; tgtPh = 0; end
    else tgtPh++;
  end

  // Behavioural reference model
  bit rq[3], tq[3];
  int mSt = 0;            // 0 idle, 1 armed, 2 counting
  longint mT = 0, mR = 0, mRes = 0;
  int mExp = 0; bit mPulse = 0, mPolLow = 0;
  always @(posedge clk) begin
    bit rR, rF, tR, trig, fin;
    longint tn;
    rR = rq[1] && !rq[2]; rF = !rq[1] && rq[2]; tR = tq[1] && !tq[2];
    if (!rstN) begin
      mSt = 0; mT = 0; mR = 0; mRes = 0; mExp = 0; mPulse = 0; mPolLow = 0;
      foreach (rq[i]) begin rq[i] = 0; tq[i] = 0; end
    end else begin
      if (wrEn) begin
        mExp = int'(wrData[4:0]); mPulse = wrData[8]; mPolLow = wrData[9];
        if (wrData[31]) begin mSt = 1; mT = 0; mR = 0; end
        else begin mSt = 0; mRes = 0; end
      end else if (mSt == 1) begin
        trig = mPulse ? (mPolLow ? rF : rR) : rR;
        if (trig) begin mSt = 2; mT = 0; mR = 0; end
      end else if (mSt == 2) begin
        tn = mT + (tR ? 1 : 0);
        if (tn > CNT_MAX) tn = CNT_MAX;
        if (mPulse) fin = mPolLow ? rR : rF;
        else fin = rR && (mR + 1 == (64'd1 << mExp));
        if (fin) begin mRes = tn; mSt = 0; end
        if (rR) mR++;
        mT = tn;
      end
      rq[2] = rq[1]; rq[1] = rq[0]; rq[0] = refIn;
      tq[2] = tq[1]; tq[1] = tq[0]; tq[0] = tgtIn;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R2, R7)
  bit cmpOn = 0;
  always @(negedge clk) begin
    if (cmpOn) begin
      check(busy == (mSt != 0), "R2/R7 busy vs model", busy, mSt != 0);
      check(result == (mSt != 0 ? 0 : mRes), "R7 result vs model", result, (mSt != 0 ? 0 : mRes));
    end
  end

  function automatic logic [31:0] word(bit go, bit pol, bit mode, int n);
    return {go, 21'd0, pol, mode, 3'd0, 5'(n)};
  endfunction

  task automatic writeCtrl(input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (busy && n < 40000) begin @(negedge clk); n++; end
    check(!busy, {req, " timeout"}, busy, 0);
  endtask

  function automatic longint absd(longint a);
    return a < 0 ? -a : a;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(result == 0, "R1 result after reset", result, 0);
    rstN = 1'b1;
    @(negedge clk); cmpOn = 1;
    repeat (5) @(negedge clk);

    // R3/R4: frequency, N=3, ref period 20, tgt period 4 -> 40
    writeCtrl(word(1, 0, 0, 3));
    check(busy == 1, "R2 busy after start", busy, 1);
    check(result == 0, "R7 result hidden while busy", result, 0);
    waitIdle("R3");
    check(absd(longint'(result) - 40) <= 1, "R3 frequency N=3", result, 40);

    // R4: N=0 -> 5
    writeCtrl(word(1, 0, 0, 0));
    waitIdle("R4");
    check(absd(longint'(result) - 5) <= 1, "R4 frequency N=0", result, 5);
    repeat (7) @(negedge clk);
    check(absd(longint'(result) - 5) <= 1, "R7 result held idle", result, 5);

    // R5: pulse high phase 30 cycles, tgt period 4 -> 7..8
    refHi = 30; refLo = 10;
    repeat (50) @(negedge clk);
    writeCtrl(word(1, 0, 1, 0));
    waitIdle("R5");
    check(absd(longint'(result) * 4 - 30) <= 4, "R5 high phase width", result, 7);

    // R6: pulse low phase 10 cycles -> 2..3
    writeCtrl(word(1, 1, 1, 0));
    waitIdle("R6");
    check(absd(longint'(result) * 4 - 10) <= 4, "R6 low phase width", result, 2);

    // R8: restart mid-measurement with smaller window
    refHi = 10; refLo = 10;
    repeat (50) @(negedge clk);
    writeCtrl(word(1, 0, 0, 6));
    repeat (60) @(negedge clk);
    check(busy == 1, "R8 first run still busy", busy, 1);
    writeCtrl(word(1, 0, 0, 2));
    waitIdle("R8");
    check(absd(longint'(result) - 20) <= 1, "R8 restart uses new config", result, 20);

    // R9: abort while busy, then clear while idle
    writeCtrl(word(1, 0, 0, 5));
    repeat (30) @(negedge clk);
    writeCtrl(word(0, 0, 0, 5));
    check(busy == 0, "R9 abort drops busy", busy, 0);
    check(result == 0, "R9 abort clears result", result, 0);
    writeCtrl(word(1, 0, 0, 1));
    waitIdle("R9");
    check(result != 0, "R9 nonzero before idle clear", result, 10);
    writeCtrl(word(0, 0, 0, 0));
    check(result == 0, "R9 idle clear", result, 0);
    check(busy == 0, "R9 idle clear keeps idle", busy, 0);

    // R10: N=10 -> 5120 edges, saturates at 4095
    writeCtrl(word(1, 0, 0, 10));
    waitIdle("R10");
    check(longint'(result) == CNT_MAX, "R10 saturation", result, CNT_MAX);

    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule